// File: doc/BRIEF.md
# Grouped Interrupt Status Encoder

This block gathers interrupt request lines into three fixed groups (critical, main and peripheral) and folds them into one registered 32-bit status word. Each group gets its own field in the word. The field holds a valid flag and the code of the winning request in that group. Inside a group the lowest code wins. The main and peripheral groups each have a mask register, and the critical group is never masked. A handler reads the word and takes the first valid field in the order critical, main, peripheral.

Two boost registers can raise individual peripheral sources above their own group. An active source with its high boost bit set puts the reserved code 2 into the critical field. An active source with its medium boost bit set puts the reserved code 4 into the main field. In both cases the peripheral field then names the boosted source, so the handler can go straight to it. A small register port writes the mask and boost registers and reads back all of them, including the status word.

Top module: `gise_top`

## Requirements
- R1: After reset the main mask reads 0x00010fff, the peripheral mask reads 0x7ffffc00, both boost registers read 0, and the status word is 0.
- R2: The status word is a register. It reflects the request inputs present at the clock edge that loads it, and it uses the mask and boost values held before that edge. A register write therefore first shows in the status word one edge after it is latched.
- R3: Critical field: code in bits 9:8, valid flag in bit 10. crit_req[0] is code 0, crit_req[1] is code 1 and crit_req[2] is code 3. Code 2 is the high-boost marker. The lowest active code wins, and the field reads 0 while bit 10 is clear.
- R4: Main field: code in bits 20:16, valid flag in bit 21. main_req[n] is code n and is disabled by main mask bit (16-n) = 1. Code 4 is the medium-boost marker, so main_req[4] has no effect. The lowest active code wins, and the field is 0 when invalid.
- R5: Peripheral field: code in bits 28:24, valid flag in bit 29. per_req[n] is disabled by peripheral mask bit (31-n) = 1. Without boosts, the lowest unmasked pending source wins, and the field is 0 when invalid.
- R6: Boost register bit n set for the high level makes unmasked pending source n produce critical code 2. Code 2 ranks between codes 1 and 3. The peripheral field then shows the lowest such high-boosted source.
- R7: Boost register bit n set for the medium level, with the high bit of n clear, makes unmasked pending source n produce main code 4. The peripheral field shows the lowest such source when no high-boosted source is active. A source with both bits set counts only as high.
- R8: Register select codes: 0 main mask (bits 16:0 stored), 1 peripheral mask (bits 31:10 stored), 2 high boost (bits 21:0), 3 medium boost (bits 21:0), 4 status (read-only). Bits that are not stored read 0. Writes to code 4 are ignored. Selects 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 3 | Critical request lines |
| main_req | input | 17 | Main group request lines |
| per_req | input | 22 | Peripheral request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| status_word | output | 32 | Registered encoded status |

## Verification
Two things can land in the same cycle: a mask write and a change on the request lines. The bench provokes this by raising a new main request in the very cycle that masks the previously winning source. The scoreboard expects that edge's status to encode the new requests against the old mask, and the following edge to apply the new mask. A second collision puts a high and a medium boost on the same source, and the bench judges both the critical and main fields from that one edge.

// File: rtl/gise_pkg.sv
package gise_pkg;
    localparam int FW = 5;

    typedef enum logic [2:0] {
        SEL_MMASK = 3'd0,
        SEL_PMASK = 3'd1,
        SEL_BHI   = 3'd2,
        SEL_BMED  = 3'd3,
        SEL_STAT  = 3'd4
    } sel_e;

    localparam int CRIT_VLD = 10;
    localparam int CRIT_LO  = 8;
    localparam int MAIN_VLD = 21;
    localparam int MAIN_LO  = 16;
    localparam int PER_VLD  = 29;
    localparam int PER_LO   = 24;
    localparam int MAIN_TOP = 16;
    localparam int PER_TOP  = 31;
    localparam int MED_CODE = 4;
endpackage

// File: rtl/gise_lowest.sv
module gise_lowest #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/gise_unmask.sv
module gise_unmask #(
    parameter int N = 17
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask_slice,
    output logic [N-1:0] act
);
    for (genvar g = 0; g < N; g++) begin : g_src
        assign act[g] = req[g] & ~mask_slice[N-1-g];
    end
endmodule

// File: rtl/gise_top.sv
module gise_top
    import gise_pkg::*;
#(
    parameter int MAIN_N = 17,
    parameter int PER_N  = 22,
    parameter logic [31:0] MMASK_RST = 32'h0001_0fff,
    parameter logic [31:0] PMASK_RST = 32'h7fff_fc00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        crit_req,
    input  logic [MAIN_N-1:0] main_req,
    input  logic [PER_N-1:0]  per_req,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic [31:0]       status_word
);
    localparam logic [31:0] MM_USED = ((32'h1 << MAIN_N) - 32'h1) << (MAIN_TOP + 1 - MAIN_N);
    localparam logic [31:0] PM_USED = ((32'h1 << PER_N) - 32'h1) << (PER_TOP + 1 - PER_N);
    localparam logic [MAIN_N-1:0] MED_BIT = MAIN_N'(1) << MED_CODE;

    typedef struct packed {
        logic [31:0]      mmask;
        logic [31:0]      pmask;
        logic [PER_N-1:0] bhi;
        logic [PER_N-1:0] bmed;
        logic [31:0]      status;
    } st_t;

    st_t s_d, s_q;

    logic [MAIN_N-1:0] main_act, main_vec;
    logic [PER_N-1:0]  per_act, hi_set, med_set;
    logic              hi_any, med_any;
    logic [3:0]        crit_vec;
    logic              c_hit, m_hit, hi_hit, med_hit, all_hit;
    logic [1:0]        c_idx;
    logic [FW-1:0]     m_idx, hi_idx, med_idx, all_idx, p_idx;

    gise_unmask #(.N(MAIN_N)) u_main_um (
        .req        (main_req),
        .mask_slice (s_q.mmask[MAIN_TOP -: MAIN_N]),
        .act        (main_act)
    );

    gise_unmask #(.N(PER_N)) u_per_um (
        .req        (per_req),
        .mask_slice (s_q.pmask[PER_TOP -: PER_N]),
        .act        (per_act)
    );

    always_comb begin
        hi_set   = per_act & s_q.bhi;
        med_set  = per_act & s_q.bmed & ~s_q.bhi;
        hi_any   = |hi_set;
        med_any  = |med_set;
        crit_vec = {crit_req[2], hi_any, crit_req[1], crit_req[0]};
        main_vec = (main_act & ~MED_BIT) | (med_any ? MED_BIT : '0);
    end

    gise_lowest #(.N(4), .W(2)) u_crit_enc (
        .vec (crit_vec), .hit (c_hit), .idx (c_idx)
    );
    gise_lowest #(.N(MAIN_N), .W(FW)) u_main_enc (
        .vec (main_vec), .hit (m_hit), .idx (m_idx)
    );
    gise_lowest #(.N(PER_N), .W(FW)) u_hi_enc (
        .vec (hi_set), .hit (hi_hit), .idx (hi_idx)
    );
    gise_lowest #(.N(PER_N), .W(FW)) u_med_enc (
        .vec (med_set), .hit (med_hit), .idx (med_idx)
    );
    gise_lowest #(.N(PER_N), .W(FW)) u_all_enc (
        .vec (per_act), .hit (all_hit), .idx (all_idx)
    );

    always_comb begin
        if (hi_hit)       p_idx = hi_idx;
        else if (med_hit) p_idx = med_idx;
        else              p_idx = all_idx;
    end

    // next-state process
    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_MMASK: s_d.mmask = wr_data & MM_USED;
                SEL_PMASK: s_d.pmask = wr_data & PM_USED;
                SEL_BHI:   s_d.bhi   = wr_data[PER_N-1:0];
                SEL_BMED:  s_d.bmed  = wr_data[PER_N-1:0];
                default:   ;
            endcase
        end
        s_d.status                       = '0;
        s_d.status[CRIT_VLD]             = c_hit;
        s_d.status[CRIT_LO +: 2]         = c_idx;
        s_d.status[MAIN_VLD]             = m_hit;
        s_d.status[MAIN_LO +: FW]        = m_idx;
        s_d.status[PER_VLD]              = all_hit;
        s_d.status[PER_LO +: FW]         = p_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mmask  <= MMASK_RST & MM_USED;
            s_q.pmask  <= PMASK_RST & PM_USED;
            s_q.bhi    <= '0;
            s_q.bmed   <= '0;
            s_q.status <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_MMASK: rd_data = s_q.mmask;
            SEL_PMASK: rd_data = s_q.pmask;
            SEL_BHI:   rd_data = 32'(s_q.bhi);
            SEL_BMED:  rd_data = 32'(s_q.bmed);
            SEL_STAT:  rd_data = s_q.status;
            default:   rd_data = '0;
        endcase
    end

    assign status_word = s_q.status;

    // ---------------- assertions ----------------
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    a_r3_crit_req0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(crit_req[0]) |-> status_word[CRIT_VLD] && status_word[CRIT_LO +: 2] == 2'd0);

    a_r3_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_word[CRIT_VLD] |-> status_word[CRIT_LO +: 2] == 2'd0) and
        (!status_word[MAIN_VLD] |-> status_word[MAIN_LO +: FW] == '0) and
        (!status_word[PER_VLD]  |-> status_word[PER_LO +: FW] == '0));

    a_r6_hi_marker_has_per: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[CRIT_VLD] && status_word[CRIT_LO +: 2] == 2'd2 |-> status_word[PER_VLD]);

    a_r7_med_marker_has_per: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[MAIN_VLD] && status_word[MAIN_LO +: FW] == FW'(MED_CODE) |-> status_word[PER_VLD]);

    a_r7_med_needs_boost: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && status_word[MAIN_VLD] && status_word[MAIN_LO +: FW] == FW'(MED_CODE)
        |-> $past(|s_q.bmed));

    a_r5_per_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && status_word[PER_VLD] |-> $past(|per_req));
endmodule

// File: tb/gise_top_test.sv
module gise_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [21:0] per_req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data, status_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [31:0] mm = 32'h0001_0fff;
    logic [31:0] pm = 32'h7fff_fc00;
    logic [21:0] bh = '0;
    logic [21:0] bm = '0;

    always #10 clk = ~clk;

    gise_top uut (
        .clk (clk), .rst_n (rst_n), .crit_req (crit_req), .main_req (main_req),
        .per_req (per_req), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .rd_sel (rd_sel), .rd_data (rd_data), .status_word (status_word)
    );

    function automatic logic [31:0] calc(input logic [2:0] c, input logic [16:0] m,
                                         input logic [21:0] p);
        logic [21:0] pa, hs, ms;
        int ci, mi, pi;
        logic [31:0] r;
        for (int n = 0; n < 22; n++) pa[n] = p[n] && !pm[31-n];
        hs = pa & bh;
        ms = pa & bm & ~bh;
        ci = -1;
        if (c[0]) ci = 0;
        else if (c[1]) ci = 1;
        else if (|hs) ci = 2;
        else if (c[2]) ci = 3;
        mi = -1;
        for (int n = 16; n >= 0; n--) begin
            if (n == 4) begin
                if (|ms) mi = n;
            end else if (m[n] && !mm[16-n]) mi = n;
        end
        pi = -1;
        for (int n = 21; n >= 0; n--) if (pa[n]) pi = n;
        if (|ms) for (int n = 21; n >= 0; n--) if (ms[n]) pi = n;
        if (|hs) for (int n = 21; n >= 0; n--) if (hs[n]) pi = n;
        r = '0;
        if (ci >= 0) begin r[10] = 1'b1; r[9:8] = ci[1:0]; end
        if (mi >= 0) begin r[21] = 1'b1; r[20:16] = mi[4:0]; end
        if (pi >= 0) begin r[29] = 1'b1; r[28:24] = pi[4:0]; end
        return r;
    endfunction

    task automatic cyc(input logic [2:0] c, input logic [16:0] m, input logic [21:0] p,
                       input logic we, input logic [2:0] sel, input logic [31:0] d,
                       input string tag);
        @(negedge clk);
        crit_req = c; main_req = m; per_req = p;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        sb.push_back('{calc(c, m, p), tag});
        if (we) begin
            case (sel)
                3'd0: mm = d & 32'h0001_ffff;
                3'd1: pm = d & 32'hffff_fc00;
                3'd2: bh = d[21:0];
                3'd3: bm = d[21:0];
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
        cyc(crit_req, main_req, per_req, 1'b1, sel, d, tag);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rdchk(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        rd_sel = sel;
        #1 check(rd_data, exp, tag);
    endtask

    // monitor: pops one expected item per edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(status_word, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check(status_word, 32'h0, "R1 status at reset");
        rst_n = 1'b1;
        rdchk(3'd0, 32'h0001_0fff, "R1 main mask reset");
        rdchk(3'd1, 32'h7fff_fc00, "R1 per mask reset");
        rdchk(3'd2, 32'h0, "R1 high boost reset");
        rdchk(3'd3, 32'h0, "R1 medium boost reset");

        // R3 critical ordering
        cyc(3'b101, '0, '0, 1'b0, 3'd0, '0, "R3 code0 beats code3");
        cyc(3'b100, '0, '0, 1'b0, 3'd0, '0, "R3 req2 gives code3");
        cyc(3'b110, '0, '0, 1'b0, 3'd0, '0, "R3 code1 wins");
        cyc(3'b000, '0, '0, 1'b0, 3'd0, '0, "R3 idle field zero");

        // R4 main group
        cyc(3'b000, 17'h01080, '0, 1'b0, 3'd0, '0, "R4 reset mask hides 7 and 12");
        wr(3'd0, 32'h0, "R2 write latched, old mask used");
        cyc(3'b000, 17'h01080, '0, 1'b0, 3'd0, '0, "R4 lowest code 7");
        // same cycle: mask source 7 and raise request 4
        cyc(3'b000, 17'h01090, '0, 1'b1, 3'd0, 32'h0000_0200, "R2 same-cycle old mask");
        cyc(3'b000, 17'h01090, '0, 1'b0, 3'd0, '0, "R2 new mask applies, R4 code 12");
        cyc(3'b000, 17'h00010, '0, 1'b0, 3'd0, '0, "R4 main_req 4 ignored");

        // R5 peripheral group
        cyc(3'b000, '0, 22'h000208, 1'b0, 3'd0, '0, "R5 masked per sources");
        cyc(3'b000, '0, 22'h000001, 1'b0, 3'd0, '0, "R5 per source 0 unmasked");
        wr(3'd1, 32'h0, "R5 unmask per");
        cyc(3'b000, '0, 22'h000208, 1'b0, 3'd0, '0, "R5 lowest per 3");
        wr(3'd1, 32'h1000_0000, "R5 mask per 3");
        cyc(3'b000, '0, 22'h000208, 1'b0, 3'd0, '0, "R5 per 9 after mask");

        // R6 high boost
        wr(3'd1, 32'h0, "R6 unmask per");
        wr(3'd2, 32'h0000_0200, "R6 boost 9 high");
        cyc(3'b000, '0, 22'h000208, 1'b0, 3'd0, '0, "R6 marker code 2, per 9");
        cyc(3'b010, '0, 22'h000208, 1'b0, 3'd0, '0, "R6 code1 beats marker");
        cyc(3'b100, '0, 22'h000208, 1'b0, 3'd0, '0, "R6 marker beats code3");

        // R7 medium boost
        wr(3'd2, 32'h0, "R7 clear high boost");
        wr(3'd3, 32'h0000_0008, "R7 boost 3 medium");
        cyc(3'b000, 17'h01000, 22'h000208, 1'b0, 3'd0, '0, "R7 main marker 4, per 3");
        cyc(3'b000, 17'h01000, 22'h000200, 1'b0, 3'd0, '0, "R7 no boosted active");
        cyc(3'b000, 17'h01000, 22'h000208, 1'b1, 3'd2, 32'h0000_0008, "R7 write high on 3");
        cyc(3'b000, 17'h01000, 22'h000208, 1'b0, 3'd0, '0, "R7 high overrides medium");

        // R8 register map
        wr(3'd4, 32'hffff_ffff, "R8 status write ignored");
        cyc(3'b000, 17'h01000, 22'h000208, 1'b0, 3'd0, '0, "R8 status after ignored write");
        wr(3'd1, 32'hffff_ffff, "R8 per mask all ones");
        rdchk(3'd1, 32'hffff_fc00, "R8 per mask unused bits zero");
        wr(3'd0, 32'hffff_ffff, "R8 main mask all ones");
        rdchk(3'd0, 32'h0001_ffff, "R8 main mask unused bits zero");
        rdchk(3'd5, 32'h0, "R8 unknown select reads zero");
        rdchk(3'd4, status_word, "R8 status readback");
        rdchk(3'd3, 32'h0000_0008, "R8 medium boost readback");

        cyc(3'b000, '0, '0, 1'b0, 3'd0, '0, "R3 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule